// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block runs a small 32-bit load/store instruction subset, one instruction per clock. The program counter drives a combinational instruction-memory read port. Within the same cycle the fetched word is decoded, two registers are read, the ALU runs and data memory is accessed. At the next rising edge the result is written back and the PC moves on. No instruction takes more than one cycle, and nothing overlaps or stalls.

The supported set is register-register add, subtract, and, or and set-less-than; word load and store with a base register plus a signed offset; branch-if-equal; and load-upper-immediate. Next-PC arithmetic has its own adder beside the ALU. The write-back selector has three sources: the ALU, memory read data, and the upper-immediate value. Register and memory state is seen only through the memory ports.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0. Reset clears all registers to zero.
- R2: After any instruction other than a taken branch, imem_addr_o advances by 4 at the next rising edge.
- R3: Branch-if-equal (opcode 0x04; fields rs [25:21], rt [20:16], imm [15:0]) compares rs and rt by subtraction. If the result is zero, the next PC is PC+4 plus the sign-extended immediate shifted left by 2.
- R4: Opcode 0x00 selects a register operation by bits [5:0]: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0). The result goes to register rd [15:11].
- R5: Load (opcode 0x23) puts rs plus the sign-extended imm on dmem_addr_o and writes dmem_rdata_i to register rt at the next edge.
- R6: Store (opcode 0x2B) puts rs plus the sign-extended imm on dmem_addr_o and the value of register rt on dmem_wdata_o, with dmem_we_o high for that cycle. It writes no register.
- R7: Load-upper (opcode 0x0F) writes imm into the high 16 bits of register rt and zeros into the low 16 bits.
- R8: Register 0 always reads as zero, and writes to it are dropped.
- R9: Any other opcode, or opcode 0x00 with any other function code, writes neither a register nor memory, and it advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Instruction fetch byte address (the PC) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o, combinational |
| dmem_addr_o | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store strobe, written at the rising edge |
| dmem_rdata_i | input | 32 | Load data at dmem_addr_o, combinational |

## Verification
The assertions assume that instruction memory returns a settled word for the current PC within the cycle, and that load data follows dmem_addr_o combinationally. They also assume that the PC sequence, branch and store relations can be judged from the fetched word alone. The random programs use only registers 0 to 7. Every load and store uses register 0 as base, with word-aligned offsets below 256, so each access falls inside the bench's 64-word data memory. Branches jump only a short distance forward. A cycle-accurate model in the bench checks the PC and the memory port every cycle, and a final dump compares memory contents.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LUI   = 6'h0F;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU, WB_MEM, WB_LUI
  } wb_sel_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;   // 1: rd field, 0: rt field
    logic    src_imm;  // ALU operand B from immediate
    logic    mem_we;
    logic    branch;
    wb_sel_e wb_sel;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, mem_we: 1'b0,
               branch: 1'b0, wb_sel: WB_ALU, alu_op: ALU_ADD};
    unique case (op_i)
      OP_RTYPE: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.reg_we = 1'b1;
        unique case (funct_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.reg_we = 1'b0;
        endcase
      end
      OP_LW: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
        ctrl_o.wb_sel  = WB_MEM;
      end
      OP_SW: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OP_LUI: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
        ctrl_o.wb_sel  = WB_LUI;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  logic lt;
  assign lt = $signed(a_i) < $signed(b_i);

  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, lt};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NRP  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   raddr_i [NRP],
  output logic [XLEN-1:0] rdata_o [NRP],
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : regs_q[raddr_i[p]];
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [31:0]     imem_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_tgt;
  logic [5:0]      op, funct;
  logic [AW-1:0]   rs, rt, rd, dst;
  logic [15:0]     imm;
  logic [XLEN-1:0] imm_sx, imm_hi, rs_val, rt_val, alu_b, alu_y, wb_val;
  logic            alu_zero;
  ctrl_t           ctrl;
  logic [AW-1:0]   raddr [2];
  logic [XLEN-1:0] rdata [2];

  assign op    = imem_data_i[31:26];
  assign rs    = imem_data_i[25:21];
  assign rt    = imem_data_i[20:16];
  assign rd    = imem_data_i[15:11];
  assign imm   = imem_data_i[15:0];
  assign funct = imem_data_i[5:0];

  assign imm_sx = {{(XLEN-16){imm[15]}}, imm};
  assign imm_hi = {imm, {(XLEN-16){1'b0}}};

  sc_decode u_dec (.op_i(op), .funct_i(funct), .ctrl_o(ctrl));

  assign raddr[0] = rs;
  assign raddr[1] = rt;
  assign rs_val   = rdata[0];
  assign rt_val   = rdata[1];
  assign dst      = ctrl.dst_rd ? rd : rt;

  sc_regfile #(.XLEN(XLEN), .NREG(NREG), .NRP(2)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raddr_i(raddr),
    .rdata_o(rdata),
    .we_i   (ctrl.reg_we),
    .waddr_i(dst),
    .wdata_i(wb_val)
  );

  assign alu_b = ctrl.src_imm ? imm_sx : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .a_i   (rs_val),
    .b_i   (alu_b),
    .op_i  (ctrl.alu_op),
    .y_o   (alu_y),
    .zero_o(alu_zero)
  );

  always_comb begin
    unique case (ctrl.wb_sel)
      WB_MEM:  wb_val = dmem_rdata_i;
      WB_LUI:  wb_val = imm_hi;
      default: wb_val = alu_y;
    endcase
  end

  // dedicated incrementer, independent of the ALU
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign pc_d     = (ctrl.branch && alu_zero) ? br_tgt : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_val;
  assign dmem_we_o    = ctrl.mem_we;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [5:0]      op_i,
  input logic [4:0]      rs_i,
  input logic [15:0]     imm_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic            we_i,
  input logic [XLEN-1:0] wdata_i
);
  logic [XLEN-1:0] off;
  assign off = {{(XLEN-18){imm_i[15]}}, imm_i, 2'b00};

  // R2
  pc_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_BEQ) |=> (pc_i == $past(pc_i) + XLEN'(4)));

  // R2
  br_not_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BEQ && rs_val_i != rt_val_i) |=> (pc_i == $past(pc_i) + XLEN'(4)));

  // R3
  br_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BEQ && rs_val_i == rt_val_i) |=>
      (pc_i == $past(pc_i) + XLEN'(4) + $past(off)));

  // R6
  store_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SW) |-> (we_i && wdata_i == rt_val_i));

  // R9
  no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_SW) |-> !we_i);

  // R8
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_i == 5'd0) |-> (rs_val_i == '0));
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_i    (op),
  .rs_i    (rs),
  .imm_i   (imm),
  .pc_i    (imem_addr_o),
  .rs_val_i(rs_val),
  .rt_val_i(rt_val),
  .we_i    (dmem_we_o),
  .wdata_i (dmem_wdata_o)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_ni;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dm   [64];
  logic [31:0] mdm  [64];
  logic [31:0] mreg [32];
  logic [31:0] mpc;
  bit          prev_taken;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  sc_core u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata),
    .dmem_we_o(dmem_we), .dmem_rdata_i(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dm[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (!rst_ni) for (int i = 0; i < 64; i++) dm[i] <= '0;
    else if (dmem_we) dm[dmem_addr[7:2]] <= dmem_wdata;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rd, int rs, int rt, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] rand_instr();
    logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    int k = $urandom % 11;
    int ra = $urandom % 8, rb = $urandom % 8, rc = $urandom % 8;
    case (k)
      0, 1, 2, 3: return enc_r(rc, ra, rb, fns[$urandom % 5]);
      4:  return enc_i(6'h23, 0, rb, 16'(($urandom % 64) * 4));
      5, 6: return enc_i(6'h2B, 0, rb, 16'(($urandom % 64) * 4));
      7:  return enc_i(6'h04, ra, rb, 16'(1 + $urandom % 3));
      8:  return enc_i(6'h0F, 0, rb, 16'($urandom));
      9:  return enc_r(rc, ra, rb, 6'h21);                 // unsupported funct
      default: return enc_i(6'h3F, ra, rb, 16'($urandom)); // unsupported op
    endcase
  endfunction

  // one model step at the negative edge: check ports, then advance model
  task automatic step();
    logic [31:0] ins = imem[mpc[7:2]];
    logic [5:0]  op = ins[31:26], fn = ins[5:0];
    int          rs = int'(ins[25:21]), rt = int'(ins[20:16]), rd = int'(ins[15:11]);
    logic [31:0] sx = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] a = mreg[rs], b = mreg[rt], res, addr;
    logic [31:0] npc = mpc + 4;
    bit          taken = 0;
    check(prev_taken ? "R3 pc" : "R2 pc", imem_addr, mpc);
    case (op)
      6'h00: begin
        check("R4 no store", 32'(dmem_we), 0);
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 1 : 0;
          default: res = 'x;
        endcase
        if (fn inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2A}) begin
          if (rd != 0) mreg[rd] = res;
        end
      end
      6'h23: begin
        addr = a + sx;
        check("R5 addr", dmem_addr, addr);
        check("R5 no store", 32'(dmem_we), 0);
        if (rt != 0) mreg[rt] = mdm[addr[7:2]];
      end
      6'h2B: begin
        addr = a + sx;
        check("R6 we", 32'(dmem_we), 1);
        check("R6 addr", dmem_addr, addr);
        check("R6 wdata", dmem_wdata, b);
        mdm[addr[7:2]] = b;
      end
      6'h04: begin
        check("R3 no store", 32'(dmem_we), 0);
        if (a == b) begin
          taken = 1;
          npc = mpc + 4 + {sx[29:0], 2'b00};
        end
      end
      6'h0F: begin
        check("R7 no store", 32'(dmem_we), 0);
        if (rt != 0) mreg[rt] = {ins[15:0], 16'h0000};
      end
      default: check("R9 no store", 32'(dmem_we), 0);
    endcase
    prev_taken = taken;
    mpc = npc;
  endtask

  task automatic run_prog(int ncyc);
    rst_ni = 1'b0;
    mpc = 0;
    prev_taken = 0;
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    for (int i = 0; i < 64; i++) mdm[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pc", imem_addr, 0);
    rst_ni = 1'b1;
    #1;
    step();
    for (int c = 1; c < ncyc; c++) begin
      @(negedge clk);
      step();
    end
  endtask

  initial begin
    void'($urandom(32'h5C0DE));
    rst_ni = 1'b0;
    for (int i = 0; i < 64; i++) imem[i] = enc_i(6'h04, 0, 0, 16'hFFFF);
    // directed program
    imem[0]  = enc_i(6'h0F, 0, 1, 16'h8000);       // r1 = 0x80000000
    imem[1]  = enc_i(6'h0F, 0, 2, 16'h0001);       // r2 = 0x00010000
    imem[2]  = enc_r(3, 1, 2, 6'h2A);              // r3 = 1 (signed)
    imem[3]  = enc_r(4, 2, 1, 6'h2A);              // r4 = 0
    imem[4]  = enc_r(5, 0, 2, 6'h22);              // r5 = -r2
    imem[5]  = enc_r(0, 1, 2, 6'h20);              // write to r0 dropped
    imem[6]  = enc_i(6'h2B, 0, 0, 16'd0);
    imem[7]  = enc_i(6'h2B, 0, 1, 16'd4);
    imem[8]  = enc_i(6'h2B, 0, 3, 16'd8);
    imem[9]  = enc_i(6'h23, 0, 6, 16'd4);          // r6 = mem[1]
    imem[10] = enc_i(6'h04, 6, 1, 16'd1);          // taken, skips next
    imem[11] = enc_i(6'h0F, 0, 7, 16'hFFFF);
    imem[12] = enc_i(6'h2B, 0, 7, 16'd12);
    imem[13] = enc_i(6'h2B, 0, 5, 16'd16);
    imem[14] = enc_i(6'h2B, 0, 4, 16'd20);
    imem[15] = enc_i(6'h04, 0, 0, 16'hFFFF);       // self loop
    run_prog(30);
    check("R8 r0 stays zero", dm[0], 32'h0);
    check("R7 lui value", dm[1], 32'h8000_0000);
    check("R4 slt negative lt positive", dm[2], 32'h1);
    check("R3 branch skipped write", dm[3], 32'h0);
    check("R4 sub result", dm[4], 32'hFFFF_0000);
    check("R4 slt false", dm[5], 32'h0);
    check("R3 loop holds pc", imem_addr, 32'd60);

    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 64; i++) imem[i] = rand_instr();
      run_prog(250);
      for (int i = 0; i < 64; i++) check("R6 memory image", dm[i], mdm[i]);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog expired act=%0d exp=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule